// File: doc/BRIEF.md
# DMA Control and Status Register Bank

This block is the software-visible register bank of a 16-channel descriptor DMA. It holds a global control word, a packed interrupt word, a packed error word and a channel control word. Each channel also has its own register window with a next-descriptor pointer, a read-only buffer address, a semaphore counter and a read-only state register. Each global register has three write addresses: a plain write, a set alias (base + 0x4) and a clear alias (base + 0x8). Software can therefore change single bits without a read-modify-write.

The channel engines are outside this block and connect only through event and control signals. Engines report completion and error pulses, which the bank keeps as sticky flags. The bank drives one interrupt line per channel. It also drives the freeze and reset-request controls for each channel. A reset request is withheld while its channel reports the read-flush state, and it clears itself when the channel reports that the reset is done. Accesses use a word address and are applied in one cycle. Write data is captured on the clock edge, and read data is combinational from the address.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset, all global registers read zero, and irq_o, freeze_o, ch_rst_o, the burst enables and sema_nz_o are all low.
- R2: Control word (byte 0x000) keeps only bit 28 (burst_en_o) and bit 29 (burst8_en_o), and all other bits read zero. Plain, set (+0x4) and clear (+0x8) writes behave as load, OR and AND-NOT, and zero bits in set or clear data have no effect.
- R3: Interrupt word (byte 0x010): bit n is the sticky completion flag of channel n, and bit 16+n is its enable. irq_o[n] is high while the flag and enable are both set, and it stays high until software clears the flag or the enable.
- R4: Error word (byte 0x020): an error pulse sets bit n and raises irq_o[n] regardless of the enable. Bit 16+n is 1 for a bus error and 0 for a termination error.
- R5: A completion or error event in the same cycle as a software clear of that flag leaves the flag set.
- R6: Channel control word (byte 0x030) bit n drives freeze_o[n].
- R7: Channel control bit 16+n requests a reset of channel n. ch_rst_o[n] is held low while the channel's state is 4'h8 (read-flush).
- R8: A pending reset-request bit clears itself in the cycle after rst_done_i[n].
- R9: The next-descriptor pointer at byte 0x110 + n*0x70 is read/write and drives nxt_ptr_o[n].
- R10: Byte 0x130 + n*0x70 reads the buffer address reported by channel n. Byte 0x150 + n*0x70 reads its 4-bit state in bits 3:0. Writes to either address are ignored.
- R11: The semaphore at byte 0x140 + n*0x70 adds its 8-bit write data to a count, and each sema_dec_i[n] pulse subtracts one. The count saturates at 0 and at 255. sema_nz_o[n] is high when the count is non-zero.
- R12: Unmapped addresses read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 10 | Word address (byte offset / 4) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| cmpl_evt_i | input | 16 | Completion pulse per channel |
| err_evt_i | input | 16 | Error pulse per channel |
| bus_err_i | input | 16 | Error type alongside err_evt_i: 1 = bus error |
| ch_state_i | input | 64 | 4-bit state per channel, 4'h8 = read-flush |
| rst_done_i | input | 16 | Channel reset finished |
| sema_dec_i | input | 16 | Semaphore decrement pulse per channel |
| buf_addr_i | input | 512 | 32-bit current buffer address per channel |
| irq_o | output | 16 | Interrupt line per channel |
| freeze_o | output | 16 | Freeze per channel |
| ch_rst_o | output | 16 | Gated reset request per channel |
| burst_en_o | output | 1 | Burst enable |
| burst8_en_o | output | 1 | Eight-beat burst enable |
| nxt_ptr_o | output | 512 | 32-bit next-descriptor pointer per channel |
| sema_nz_o | output | 16 | Semaphore count non-zero per channel |

## Verification
The alias logic is tried with three write forms on the same register: all-ones plain loads, single-bit set and clear writes, and writes with mixed data. These show whether set and clear leave the unaddressed bits alone and whether unwritable bits stay zero. Channel events are tried in several cases:
- completion with and without the enable set, which separates the sticky flag from the interrupt line;
- error with and without the bus-error type, which separates the two error types;
- an event in the same cycle as a clear, which shows which source has priority.

Reset requests are issued while the channel reports read-flush and again after it leaves that state, which separates a held request from a lost one. Semaphore sequences that run past zero and past 255 check both saturation limits.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  // word addresses (byte offset >> 2)
  localparam int unsigned A_CTRL0   = 'h00;
  localparam int unsigned A_IRQ     = 'h04;
  localparam int unsigned A_ERR     = 'h08;
  localparam int unsigned A_CHCTL   = 'h0C;
  localparam int unsigned OFS_SET   = 1;
  localparam int unsigned OFS_CLR   = 2;
  localparam int unsigned A_CH_NXT  = 'h44;
  localparam int unsigned A_CH_BUF  = 'h4C;
  localparam int unsigned A_CH_SEMA = 'h50;
  localparam int unsigned A_CH_DBG  = 'h54;
  localparam int unsigned CH_STRIDE = 'h1C;
  localparam int unsigned HI_OFS    = 16;
  localparam int unsigned BURST_BIT = 28;
  localparam int unsigned BURST8_BIT = 29;
  localparam logic [3:0]  ST_RD_FLUSH = 4'h8;

  typedef struct packed {
    logic plain;
    logic set;
    logic clr;
  } alias_wr_t;

  function automatic alias_wr_t alias_hit(input int unsigned a, input int unsigned base,
                                          input logic wr);
    alias_wr_t r;
    r.plain = wr && (a == base);
    r.set   = wr && (a == base + OFS_SET);
    r.clr   = wr && (a == base + OFS_CLR);
    return r;
  endfunction
endpackage

// File: rtl/dma_csr_alias_reg.sv
module dma_csr_alias_reg
  import dma_csr_pkg::*;
#(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  alias_wr_t    wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_clr_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, sw_d, nxt_d;

  always_comb begin
    sw_d = q_q;
    if (wr_i.plain)    sw_d = wdata_i;
    else if (wr_i.set) sw_d = q_q | wdata_i;
    else if (wr_i.clr) sw_d = q_q & ~wdata_i;
    // hardware set wins over any software clear
    nxt_d = (((sw_d & WMASK) & ~hw_clr_i) | hw_set_i) & WMASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nxt_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/dma_csr_chan_win.sv
module dma_csr_chan_win
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned CH     = 0,
  parameter int unsigned SEMA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic [31:0]       buf_addr_i,
  input  logic [3:0]        state_i,
  input  logic              sema_dec_i,
  output logic [31:0]       nxt_ptr_o,
  output logic              sema_nz_o,
  output logic [31:0]       rdata_o
);
  localparam int unsigned NXT_A  = A_CH_NXT  + CH * CH_STRIDE;
  localparam int unsigned BUF_A  = A_CH_BUF  + CH * CH_STRIDE;
  localparam int unsigned SEMA_A = A_CH_SEMA + CH * CH_STRIDE;
  localparam int unsigned DBG_A  = A_CH_DBG  + CH * CH_STRIDE;
  localparam logic [SEMA_W:0] SEMA_MAX = {1'b0, {SEMA_W{1'b1}}};

  int unsigned a;
  logic [31:0]       nxt_q;
  logic [SEMA_W-1:0] sema_q;
  logic [SEMA_W:0]   sema_sum;

  assign a = 32'(addr_i);

  always_comb begin
    sema_sum = {1'b0, sema_q};
    if (wr_i && a == SEMA_A) sema_sum = sema_sum + {1'b0, wdata_i[SEMA_W-1:0]};
    if (sema_dec_i && sema_sum != '0) sema_sum = sema_sum - 1'b1;
    if (sema_sum > SEMA_MAX) sema_sum = SEMA_MAX;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q  <= '0;
      sema_q <= '0;
    end else begin
      if (wr_i && a == NXT_A) nxt_q <= wdata_i;
      sema_q <= sema_sum[SEMA_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (a == NXT_A)       rdata_o = nxt_q;
    else if (a == BUF_A)  rdata_o = buf_addr_i;
    else if (a == SEMA_A) rdata_o = 32'(sema_q);
    else if (a == DBG_A)  rdata_o = 32'(state_i);
  end

  assign nxt_ptr_o = nxt_q;
  assign sema_nz_o = |sema_q;
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 16,  // at most 16: bit n / bit 16+n layout
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned SEMA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  input  logic [NUM_CH-1:0]    cmpl_evt_i,
  input  logic [NUM_CH-1:0]    err_evt_i,
  input  logic [NUM_CH-1:0]    bus_err_i,
  input  logic [NUM_CH*4-1:0]  ch_state_i,
  input  logic [NUM_CH-1:0]    rst_done_i,
  input  logic [NUM_CH-1:0]    sema_dec_i,
  input  logic [NUM_CH*32-1:0] buf_addr_i,
  output logic [NUM_CH-1:0]    irq_o,
  output logic [NUM_CH-1:0]    freeze_o,
  output logic [NUM_CH-1:0]    ch_rst_o,
  output logic                 burst_en_o,
  output logic                 burst8_en_o,
  output logic [NUM_CH*32-1:0] nxt_ptr_o,
  output logic [NUM_CH-1:0]    sema_nz_o
);
  localparam logic [31:0] LO_MASK   = (33'h1 << NUM_CH) - 1;
  localparam logic [31:0] PAIR_MASK = LO_MASK | (LO_MASK << HI_OFS);
  localparam logic [31:0] CTRL_MASK = (32'h1 << BURST_BIT) | (32'h1 << BURST8_BIT);

  logic        wr;
  int unsigned a;
  alias_wr_t   wr_ctrl, wr_irq, wr_err, wr_chctl;
  logic [31:0] ctrl_q, irq_q, err_q, chctl_q;
  logic [31:0] irq_set, err_set, err_clr, chctl_clr;
  logic [31:0] ch_rd [NUM_CH];
  logic [31:0] ch_rd_or, glob_rd;

  assign wr = req_i & we_i;
  assign a  = 32'(addr_i);

  assign wr_ctrl  = alias_hit(a, A_CTRL0, wr);
  assign wr_irq   = alias_hit(a, A_IRQ,   wr);
  assign wr_err   = alias_hit(a, A_ERR,   wr);
  assign wr_chctl = alias_hit(a, A_CHCTL, wr);

  always_comb begin
    irq_set   = 32'(cmpl_evt_i);
    err_set   = 32'(err_evt_i) | (32'(err_evt_i & bus_err_i) << HI_OFS);
    err_clr   = 32'(err_evt_i & ~bus_err_i) << HI_OFS;
    chctl_clr = 32'(rst_done_i) << HI_OFS;
  end

  dma_csr_alias_reg #(.W(32), .WMASK(CTRL_MASK)) u_ctrl (
    .clk_i, .rst_ni, .wr_i(wr_ctrl), .wdata_i,
    .hw_clr_i('0), .hw_set_i('0), .q_o(ctrl_q));

  dma_csr_alias_reg #(.W(32), .WMASK(PAIR_MASK)) u_irq (
    .clk_i, .rst_ni, .wr_i(wr_irq), .wdata_i,
    .hw_clr_i('0), .hw_set_i(irq_set), .q_o(irq_q));

  dma_csr_alias_reg #(.W(32), .WMASK(PAIR_MASK)) u_err (
    .clk_i, .rst_ni, .wr_i(wr_err), .wdata_i,
    .hw_clr_i(err_clr), .hw_set_i(err_set), .q_o(err_q));

  dma_csr_alias_reg #(.W(32), .WMASK(PAIR_MASK)) u_chctl (
    .clk_i, .rst_ni, .wr_i(wr_chctl), .wdata_i,
    .hw_clr_i(chctl_clr), .hw_set_i('0), .q_o(chctl_q));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    dma_csr_chan_win #(.ADDR_W(ADDR_W), .CH(n), .SEMA_W(SEMA_W)) u_win (
      .clk_i, .rst_ni,
      .wr_i       (wr),
      .addr_i,
      .wdata_i,
      .buf_addr_i (buf_addr_i[n*32 +: 32]),
      .state_i    (ch_state_i[n*4 +: 4]),
      .sema_dec_i (sema_dec_i[n]),
      .nxt_ptr_o  (nxt_ptr_o[n*32 +: 32]),
      .sema_nz_o  (sema_nz_o[n]),
      .rdata_o    (ch_rd[n]));

    assign ch_rst_o[n] = chctl_q[HI_OFS+n] && (ch_state_i[n*4 +: 4] != ST_RD_FLUSH);
  end

  always_comb begin
    ch_rd_or = '0;
    for (int n = 0; n < NUM_CH; n++) ch_rd_or |= ch_rd[n];
  end

  // globals occupy words 0..15; alias slot 3 of each group is unmapped
  always_comb begin
    glob_rd = '0;
    if (addr_i[ADDR_W-1:4] == '0 && addr_i[1:0] != 2'd3) begin
      case (addr_i[3:2])
        2'd0:    glob_rd = ctrl_q;
        2'd1:    glob_rd = irq_q;
        2'd2:    glob_rd = err_q;
        default: glob_rd = chctl_q;
      endcase
    end
  end

  assign rdata_o     = glob_rd | ch_rd_or;
  assign irq_o       = (irq_q[NUM_CH-1:0] & irq_q[HI_OFS +: NUM_CH]) | err_q[NUM_CH-1:0];
  assign freeze_o    = chctl_q[NUM_CH-1:0];
  assign burst_en_o  = ctrl_q[BURST_BIT];
  assign burst8_en_o = ctrl_q[BURST8_BIT];
endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk #(
  parameter int unsigned NUM_CH = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [NUM_CH-1:0]   cmpl_evt_i,
  input logic [NUM_CH-1:0]   err_evt_i,
  input logic [NUM_CH*4-1:0] ch_state_i,
  input logic [NUM_CH-1:0]   rst_done_i,
  input logic [NUM_CH-1:0]   sema_dec_i,
  input logic [NUM_CH-1:0]   irq_en_i,
  input logic [NUM_CH-1:0]   irq_o,
  input logic [NUM_CH-1:0]   freeze_o,
  input logic [NUM_CH-1:0]   ch_rst_o,
  input logic                burst_en_o,
  input logic                burst8_en_o,
  input logic [NUM_CH-1:0]   sema_nz_o
);
  logic wr;
  assign wr = req_i & we_i;

  p_ctl_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable({burst_en_o, burst8_en_o}));

  p_freeze_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr |=> $stable(freeze_o));

  for (genvar n = 0; n < NUM_CH; n++) begin : g_a
    p_cmpl_irq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmpl_evt_i[n] && irq_en_i[n] && !wr |=> irq_o[n]);

    p_irq_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[n] && !wr |=> irq_o[n]);

    p_err_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_evt_i[n] |=> irq_o[n]);

    p_flush_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_state_i[n*4 +: 4] == 4'h8 |-> !ch_rst_o[n]);

    p_rst_selfclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_done_i[n] && !wr |=> !ch_rst_o[n]);

    p_sema_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr && !sema_dec_i[n] |=> $stable(sema_nz_o[n]));
  end
endmodule

bind dma_csr_bank dma_csr_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .cmpl_evt_i, .err_evt_i, .ch_state_i,
  .rst_done_i, .sema_dec_i,
  .irq_en_i(irq_q[16 +: NUM_CH]),
  .irq_o, .freeze_o, .ch_rst_o, .burst_en_o, .burst8_en_o, .sema_nz_o);

// File: tb/sim_dma_csr_bank.sv
module sim_dma_csr_bank;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0, we = 1'b0;
  logic [9:0]   addr = '0;
  logic [31:0]  wdata = '0, rdata;
  logic [15:0]  cmpl = '0, err = '0, berr = '0, rdone = '0, sdec = '0;
  logic [63:0]  state = '0;
  logic [511:0] bufa = '0;
  logic [15:0]  irq, frz, crst, snz;
  logic         bst, bst8;
  logic [511:0] nxt;
  int           n_run = 0, n_fail = 0;
  logic [31:0]  r;

  always #4 clk = ~clk;

  dma_csr_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cmpl_evt_i(cmpl), .err_evt_i(err),
    .bus_err_i(berr), .ch_state_i(state), .rst_done_i(rdone),
    .sema_dec_i(sdec), .buf_addr_i(bufa), .irq_o(irq), .freeze_o(frz),
    .ch_rst_o(crst), .burst_en_o(bst), .burst8_en_o(bst8),
    .nxt_ptr_o(nxt), .sema_nz_o(snz));

  // {wr addr, wr data, rd addr, expected}
  localparam logic [83:0] TBL [0:10] = '{
    {10'h000, 32'hFFFF_FFFF, 10'h000, 32'h3000_0000},  // R2 plain, mask
    {10'h002, 32'h1000_0000, 10'h000, 32'h2000_0000},  // R2 clear alias
    {10'h001, 32'h1000_0000, 10'h000, 32'h3000_0000},  // R2 set alias
    {10'h000, 32'h0000_0000, 10'h000, 32'h0000_0000},  // R2 plain zero
    {10'h005, 32'h0003_0000, 10'h004, 32'h0003_0000},  // R3 enables set
    {10'h006, 32'h0001_0000, 10'h004, 32'h0002_0000},  // R3 enable clear
    {10'h00D, 32'h0000_00A5, 10'h00C, 32'h0000_00A5},  // R6 set
    {10'h00E, 32'h0000_0005, 10'h00C, 32'h0000_00A0},  // R6 clear
    {10'h098, 32'hDEAD_BEE0, 10'h098, 32'hDEAD_BEE0},  // R9 ch3 pointer
    {10'h003, 32'hFFFF_FFFF, 10'h003, 32'h0000_0000},  // R12 unmapped
    {10'h00C, 32'h0000_0000, 10'h00C, 32'h0000_0000}   // R6 plain zero
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    req = 1'b0; we = 1'b0; addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(10'h000, r); chk("R1 ctrl", r, 0);
    rd(10'h004, r); chk("R1 irq reg", r, 0);
    rd(10'h008, r); chk("R1 err reg", r, 0);
    rd(10'h00C, r); chk("R1 chctl", r, 0);
    chk("R1 outputs", {irq, frz, crst}, 0);
    chk("R1 bursts/sema", {30'd0, bst, bst8} | 32'(snz), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      wr(TBL[i][83:74], TBL[i][73:42]);
      rd(TBL[i][41:32], r);
      chk($sformatf("table %0d", i), r, TBL[i][31:0]);
      if (i == 2) chk("R2 burst pins", {30'd0, bst8, bst}, 32'h3);
      if (i == 6) chk("R6 freeze_o", 32'(frz), 32'hA5);
      if (i == 8) chk("R9 nxt_ptr_o", nxt[3*32 +: 32], 32'hDEAD_BEE0);
    end

    // R3 completion flags and enable
    wr(10'h004, 32'h0000_0000);
    wr(10'h005, 32'h0004_0000);
    @(negedge clk); cmpl = 16'h0024;
    @(negedge clk); cmpl = '0;
    rd(10'h004, r); chk("R3 flags", r, 32'h0004_0024);
    chk("R3 irq only enabled", 32'(irq), 32'h0004);
    repeat (3) @(negedge clk);
    chk("R3 sticky", 32'(irq), 32'h0004);
    wr(10'h006, 32'h0000_0004);
    chk("R3 cleared", 32'(irq), 32'h0000);

    // R5 event vs clear same cycle
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 10'h006; wdata = 32'h0000_0024; cmpl = 16'h0004;
    @(negedge clk);
    req = 1'b0; we = 1'b0; cmpl = '0;
    rd(10'h004, r); chk("R5 flag kept", r, 32'h0004_0004);

    // R4 error types
    wr(10'h004, 32'h0000_0000);
    @(negedge clk); err = 16'h0082; berr = 16'h0080;
    @(negedge clk); err = '0; berr = '0;
    rd(10'h008, r); chk("R4 bus vs term", r, 32'h0080_0082);
    chk("R4 irq", 32'(irq), 32'h0082);
    wr(10'h00A, 32'h0080_0082);
    chk("R4 irq cleared", 32'(irq), 32'h0);

    // R7 / R8 reset request
    state[4*4 +: 4] = 4'h8;
    wr(10'h00D, 32'h0010_0000);
    chk("R7 held in flush", 32'(crst), 32'h0);
    rd(10'h00C, r); chk("R7 pending bit", r, 32'h0010_0000);
    state[4*4 +: 4] = 4'h2;
    #1 chk("R7 released", 32'(crst), 32'h0010);
    @(negedge clk); rdone = 16'h0010;
    @(negedge clk); rdone = '0;
    chk("R8 self-clear out", 32'(crst), 32'h0);
    rd(10'h00C, r); chk("R8 self-clear reg", r, 32'h0);

    // R10 read-only channel fields
    bufa[1*32 +: 32] = 32'h1234_5678;
    state[1*4 +: 4] = 4'h5;
    wr(10'h068, 32'hFFFF_FFFF);
    wr(10'h070, 32'hFFFF_FFFF);
    rd(10'h068, r); chk("R10 buf addr", r, 32'h1234_5678);
    rd(10'h070, r); chk("R10 state", r, 32'h5);

    // R11 semaphore
    wr(10'h050, 32'd2);
    rd(10'h050, r); chk("R11 add", r, 32'd2);
    chk("R11 nz", 32'(snz[0]), 1);
    @(negedge clk); sdec[0] = 1'b1;
    repeat (3) @(negedge clk);
    sdec[0] = 1'b0;
    rd(10'h050, r); chk("R11 floor", r, 32'd0);
    chk("R11 zero", 32'(snz[0]), 0);
    wr(10'h050, 32'd250);
    wr(10'h050, 32'd10);
    rd(10'h050, r); chk("R11 ceiling", r, 32'd255);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule